// File: doc/BRIEF.md
# Inclusive Cache Back-Invalidation Filter

This controller sits beside an inclusive last-level cache. It holds an exact presence vector for every last-level block, with one bit per upper-level cache above it. When the last level evicts a block, the controller sends back-invalidation requests only to the upper caches whose bit is set. When no bit is set, it finishes the eviction at once.

Upper caches tell the controller about their own changes. A fill grant sets that cache's bit and can clear the bit of the victim the cache chose at miss time, both in the same cycle. A separate notice clears a bit when an upper cache drops a line later.

For a capacity eviction, a victim that is still present upward can be swapped. The controller asks the replacement logic for another way, at most `MAX_RESEL` times. After that, the current victim is invalidated. A coherence-driven eviction is never swapped. When an upper cache acknowledges an invalidation with dirty data, the data goes into a one-entry buffer. That buffer drains straight to memory and does not pass through the last-level cache.

The FSM has five states:
- `S_IDLE` waits for an eviction and goes to `S_LOOKUP` when one is accepted.
- `S_LOOKUP` reads the presence vector of the current victim:
  - all bits clear: goes to `S_DONE`;
  - bits set, capacity eviction, budget left: goes to `S_RESEL`;
  - otherwise: goes to `S_INVAL`.
- `S_RESEL` waits for a new way and then returns to `S_LOOKUP`.
- `S_INVAL` waits until every targeted cache has acknowledged and then goes to `S_DONE`.
- `S_DONE` pulses completion for one cycle, clears the victim's presence entry and returns to `S_IDLE`.

Top module: `backinv_filter`

## Requirements
- R1: After reset, `ev_ready` is 1 and `inv_valid`, `wb_valid`, `resel_req` and `ev_done` are 0. All presence bits are clear.
- R2: A fill grant on port c (bit c of `fill_valid`, with set and way in slice c of `fill_set`/`fill_way`) sets cache c's presence bit for that entry on the next edge.
- R3: On an eviction, bit c of `inv_valid` is raised only if cache c's presence bit for the victim's set and way is set. With no bit set, `ev_done` pulses and no request is raised.
- R4: An upper-level eviction notice on port c clears cache c's bit for the named set and way.
- R5: A fill grant carrying a victim (bit c of `fill_vic_valid`) clears cache c's bit for the victim entry in the same cycle that it sets the filled entry.
- R6: `ev_done` is not raised until every targeted cache has had its acknowledgement accepted. Acknowledgements are accepted in any order, one per cycle.
- R7: A dirty accepted acknowledgement presents the victim address and that cache's data on `wb_addr`/`wb_data` with `wb_valid` held until `wb_ready`. A clean acknowledgement produces no write-back.
- R8: While the write-back buffer is full, `inv_ack_ready` is all zero and pending requests stay raised.
- R9: A capacity eviction (`ev_coh`=0) of a present victim raises `resel_req` with the victim's set. The way returned on `resel_valid` becomes the new victim and is looked up again.
- R10: At most `MAX_RESEL` (default 2) reselections happen per eviction. After that, the current victim is invalidated and reported on `ev_done_way`.
- R11: A coherence eviction (`ev_coh`=1) never raises `resel_req`.
- R12: Completion clears every presence bit of the final victim. A second eviction of that entry raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Last-level eviction request |
| ev_ready | output | 1 | Request accepted (high in S_IDLE) |
| ev_set | input | SET_W | Victim set |
| ev_way | input | WAY_W | Victim way |
| ev_addr | input | ADDR_W | Victim block address |
| ev_coh | input | 1 | 1 = coherence-driven, no reselection |
| ev_done | output | 1 | One-cycle completion pulse |
| ev_done_way | output | WAY_W | Way finally evicted |
| resel_req | output | 1 | Ask replacement logic for another victim |
| resel_set | output | SET_W | Set of the victim being replaced |
| resel_cur_way | output | WAY_W | Way currently rejected |
| resel_valid | input | 1 | New victim supplied |
| resel_way | input | WAY_W | New victim way |
| resel_addr | input | ADDR_W | New victim address |
| fill_valid | input | NUM_UP | Fill grant per upper cache |
| fill_set | input | NUM_UP*SET_W | Filled set per cache |
| fill_way | input | NUM_UP*WAY_W | Filled way per cache |
| fill_vic_valid | input | NUM_UP | Fill carries an upper-level victim |
| fill_vic_set | input | NUM_UP*SET_W | Victim's last-level set |
| fill_vic_way | input | NUM_UP*WAY_W | Victim's last-level way |
| note_valid | input | NUM_UP | Upper-level eviction notice |
| note_set | input | NUM_UP*SET_W | Notice set |
| note_way | input | NUM_UP*WAY_W | Notice way |
| inv_valid | output | NUM_UP | Back-invalidation request per cache |
| inv_addr | output | ADDR_W | Address to invalidate |
| inv_ack | input | NUM_UP | Acknowledgement per cache |
| inv_dirty | input | NUM_UP | Acknowledgement carries dirty data |
| inv_data | input | NUM_UP*DATA_W | Dirty data per cache |
| inv_ack_ready | output | NUM_UP | Acknowledgement accepted (one-hot) |
| wb_valid | output | 1 | Write-back to memory valid |
| wb_ready | input | 1 | Memory accepts write-back |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |

## Verification
The bench first gives one entry two sharers and acknowledges them in reverse order with the first one dirty. It then holds memory not ready, so that the second acknowledgement has to stall. A design that completed on the first acknowledgement, or that dropped the stalled one, would raise `ev_done` early or lose a pending request. Other tests cover a fill whose victim lies in the same set as the fill, and a notice that cancels a fill. A design that applied the victim clear after the set, or ignored the notice, would send needless invalidations. The reselection budget is run out with every candidate present, and the test expects exactly two requests and then an invalidation of the third way. A design that stopped early would evict a present line, and one that never stopped would hang.

// File: rtl/bif_pkg.sv
package bif_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOOKUP = 3'd1,
        S_RESEL  = 3'd2,
        S_INVAL  = 3'd3,
        S_DONE   = 3'd4
    } bif_state_e;
endpackage

// File: rtl/bif_presence.sv
module bif_presence #(
    parameter int NUM_UP  = 2,
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [NUM_UP-1:0]             rd_bits,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    input  logic [NUM_UP-1:0]             fill_v,
    input  logic [NUM_UP-1:0][IDX_W-1:0]  fill_idx,
    input  logic [NUM_UP-1:0]             fvic_v,
    input  logic [NUM_UP-1:0][IDX_W-1:0]  fvic_idx,
    input  logic [NUM_UP-1:0]             note_v,
    input  logic [NUM_UP-1:0][IDX_W-1:0]  note_idx
);
    logic [NUM_UP-1:0] pres_q [ENTRIES];
    logic [NUM_UP-1:0] pres_d [ENTRIES];

    assign rd_bits = pres_q[rd_idx];

    // clears first, fill set last so a grant wins over a clear of the same entry
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            pres_d[e] = pres_q[e];
            if (clr_en && clr_idx == IDX_W'(e)) pres_d[e] = '0;
            for (int c = 0; c < NUM_UP; c++) begin
                if (note_v[c] && note_idx[c] == IDX_W'(e)) pres_d[e][c] = 1'b0;
                if (fvic_v[c] && fvic_idx[c] == IDX_W'(e)) pres_d[e][c] = 1'b0;
                if (fill_v[c] && fill_idx[c] == IDX_W'(e)) pres_d[e][c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) pres_q[e] <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) pres_q[e] <= pres_d[e];
        end
    end

    for (genvar c = 0; c < NUM_UP; c++) begin : g_chk
        // R2
        fill_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fill_v[c] |=> pres_q[$past(fill_idx[c])][c]);
        // R4
        note_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (note_v[c] && !(fill_v[c] && fill_idx[c] == note_idx[c]))
            |=> !pres_q[$past(note_idx[c])][c]);
    end
endmodule

// File: rtl/bif_ack_pick.sv
module bif_ack_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pick
        assign gnt[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/bif_wbbuf.sv
module bif_wbbuf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic              full,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            vld_q  <= 1'b1;
            addr_q <= load_addr;
            data_q <= load_data;
        end else if (vld_q && out_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign full      = vld_q;
    assign out_valid = vld_q;
    assign out_addr  = addr_q;
    assign out_data  = data_q;

    // R7
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));
endmodule

// File: rtl/backinv_filter.sv
module backinv_filter
    import bif_pkg::*;
#(
    parameter int NUM_UP    = 2,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MAX_RESEL = 2,
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_valid,
    output logic                     ev_ready,
    input  logic [SET_W-1:0]         ev_set,
    input  logic [WAY_W-1:0]         ev_way,
    input  logic [ADDR_W-1:0]        ev_addr,
    input  logic                     ev_coh,
    output logic                     ev_done,
    output logic [WAY_W-1:0]         ev_done_way,
    output logic                     resel_req,
    output logic [SET_W-1:0]         resel_set,
    output logic [WAY_W-1:0]         resel_cur_way,
    input  logic                     resel_valid,
    input  logic [WAY_W-1:0]         resel_way,
    input  logic [ADDR_W-1:0]        resel_addr,
    input  logic [NUM_UP-1:0]        fill_valid,
    input  logic [NUM_UP*SET_W-1:0]  fill_set,
    input  logic [NUM_UP*WAY_W-1:0]  fill_way,
    input  logic [NUM_UP-1:0]        fill_vic_valid,
    input  logic [NUM_UP*SET_W-1:0]  fill_vic_set,
    input  logic [NUM_UP*WAY_W-1:0]  fill_vic_way,
    input  logic [NUM_UP-1:0]        note_valid,
    input  logic [NUM_UP*SET_W-1:0]  note_set,
    input  logic [NUM_UP*WAY_W-1:0]  note_way,
    output logic [NUM_UP-1:0]        inv_valid,
    output logic [ADDR_W-1:0]        inv_addr,
    input  logic [NUM_UP-1:0]        inv_ack,
    input  logic [NUM_UP-1:0]        inv_dirty,
    input  logic [NUM_UP*DATA_W-1:0] inv_data,
    output logic [NUM_UP-1:0]        inv_ack_ready,
    output logic                     wb_valid,
    input  logic                     wb_ready,
    output logic [ADDR_W-1:0]        wb_addr,
    output logic [DATA_W-1:0]        wb_data
);
    localparam int IDX_W   = SET_W + WAY_W;
    localparam int ENTRIES = SETS * WAYS;
    localparam int CNT_W   = $clog2(MAX_RESEL + 2);

    bif_state_e        state_q, state_d;
    logic [SET_W-1:0]  set_q;
    logic [WAY_W-1:0]  way_q;
    logic [ADDR_W-1:0] addr_q;
    logic              coh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_UP-1:0] pend_q;

    logic [NUM_UP-1:0] rd_bits;
    logic [IDX_W-1:0]  cur_idx;
    logic              clr_en;
    logic [NUM_UP-1:0] ack_req, ack_gnt;
    logic              wb_full, wb_load;
    logic [DATA_W-1:0] wb_load_data;

    logic [NUM_UP-1:0][IDX_W-1:0] fill_idx, fvic_idx, note_idx;

    for (genvar c = 0; c < NUM_UP; c++) begin : g_idx
        assign fill_idx[c] = {fill_set[c*SET_W +: SET_W],     fill_way[c*WAY_W +: WAY_W]};
        assign fvic_idx[c] = {fill_vic_set[c*SET_W +: SET_W], fill_vic_way[c*WAY_W +: WAY_W]};
        assign note_idx[c] = {note_set[c*SET_W +: SET_W],     note_way[c*WAY_W +: WAY_W]};
    end

    assign cur_idx = {set_q, way_q};

    bif_presence #(.NUM_UP(NUM_UP), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pres (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_bits  (rd_bits),
        .clr_en   (clr_en),
        .clr_idx  (cur_idx),
        .fill_v   (fill_valid),
        .fill_idx (fill_idx),
        .fvic_v   (fill_vic_valid),
        .fvic_idx (fvic_idx),
        .note_v   (note_valid),
        .note_idx (note_idx)
    );

    assign ack_req = (state_q == S_INVAL && !wb_full) ? (inv_ack & pend_q) : '0;

    bif_ack_pick #(.N(NUM_UP)) u_pick (
        .req (ack_req),
        .gnt (ack_gnt)
    );

    always_comb begin
        wb_load_data = '0;
        for (int c = 0; c < NUM_UP; c++)
            if (ack_gnt[c]) wb_load_data = inv_data[c*DATA_W +: DATA_W];
    end
    assign wb_load = |(ack_gnt & inv_dirty);

    bif_wbbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wb_load),
        .load_addr (addr_q),
        .load_data (wb_load_data),
        .full      (wb_full),
        .out_valid (wb_valid),
        .out_ready (wb_ready),
        .out_addr  (wb_addr),
        .out_data  (wb_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (ev_valid) state_d = S_LOOKUP;
            S_LOOKUP: begin
                if (rd_bits == '0)
                    state_d = S_DONE;
                else if (!coh_q && cnt_q < CNT_W'(MAX_RESEL))
                    state_d = S_RESEL;
                else
                    state_d = S_INVAL;
            end
            S_RESEL:  if (resel_valid) state_d = S_LOOKUP;
            S_INVAL:  if (pend_q == '0) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // victim context and pending targets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q  <= '0;
            way_q  <= '0;
            addr_q <= '0;
            coh_q  <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            if (state_q == S_IDLE && ev_valid) begin
                set_q  <= ev_set;
                way_q  <= ev_way;
                addr_q <= ev_addr;
                coh_q  <= ev_coh;
                cnt_q  <= '0;
            end
            if (state_q == S_RESEL && resel_valid) begin
                way_q  <= resel_way;
                addr_q <= resel_addr;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (state_q == S_LOOKUP && state_d == S_INVAL)
                pend_q <= rd_bits;
            else
                pend_q <= pend_q & ~ack_gnt;
        end
    end

    // outputs
    always_comb begin
        ev_ready      = (state_q == S_IDLE);
        ev_done       = (state_q == S_DONE);
        ev_done_way   = way_q;
        resel_req     = (state_q == S_RESEL);
        resel_set     = set_q;
        resel_cur_way = way_q;
        inv_valid     = (state_q == S_INVAL) ? pend_q : '0;
        inv_addr      = addr_q;
        inv_ack_ready = ack_gnt;
        clr_en        = (state_q == S_DONE);
    end

    // R3
    inval_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INVAL && $past(state_q) == S_LOOKUP) |-> (pend_q != '0));
    // R6
    done_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> (inv_valid == '0));
    // R6
    one_ack_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_ack_ready));
    // R8
    stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (inv_ack_ready == '0));
    // R10
    resel_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resel_req |-> (cnt_q < CNT_W'(MAX_RESEL)));
    // R11
    coh_no_resel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resel_req |-> !coh_q);
endmodule

// File: tb/sim_backinv_filter.sv
module sim_backinv_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        ev_valid = 0, ev_coh = 0;
    logic        ev_ready, ev_done, resel_req, wb_valid;
    logic [3:0]  ev_set = 0, resel_set;
    logic [1:0]  ev_way = 0, ev_done_way, resel_cur_way, resel_way = 0;
    logic [15:0] ev_addr = 0, resel_addr = 0, inv_addr, wb_addr;
    logic        resel_valid = 0, wb_ready = 0;
    logic [1:0]  fill_valid = 0, fill_vic_valid = 0, note_valid = 0;
    logic [7:0]  fill_set = 0, fill_vic_set = 0, note_set = 0;
    logic [3:0]  fill_way = 0, fill_vic_way = 0, note_way = 0;
    logic [1:0]  inv_valid, inv_ack = 0, inv_dirty = 0, inv_ack_ready;
    logic [63:0] inv_data = 0;
    logic [31:0] wb_data;

    int checks = 0, errors = 0, cyc = 0;

    backinv_filter u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input int c, input int s, input int w,
                           input logic vv, input int vs, input int vw);
        @(negedge clk);
        fill_valid[c] = 1'b1;
        fill_set[c*4 +: 4] = 4'(s);
        fill_way[c*2 +: 2] = 2'(w);
        fill_vic_valid[c] = vv;
        fill_vic_set[c*4 +: 4] = 4'(vs);
        fill_vic_way[c*2 +: 2] = 2'(vw);
        @(negedge clk);
        fill_valid = 0;
        fill_vic_valid = 0;
    endtask

    task automatic do_note(input int c, input int s, input int w);
        @(negedge clk);
        note_valid[c] = 1'b1;
        note_set[c*4 +: 4] = 4'(s);
        note_way[c*2 +: 2] = 2'(w);
        @(negedge clk);
        note_valid = 0;
    endtask

    // eviction with clean acks; reselection answers taken from rw*/ra*
    task automatic run_evict(input int s, input int w, input logic [15:0] a, input logic coh,
                             input int rw0, input int rw1,
                             output logic [1:0] seen, output int nres, output int dway);
        bit fin = 0;
        seen = 0; nres = 0; dway = -1;
        @(negedge clk);
        ev_valid = 1; ev_set = 4'(s); ev_way = 2'(w); ev_addr = a; ev_coh = coh;
        @(negedge clk);
        ev_valid = 0;
        for (int k = 0; k < 40 && !fin; k++) begin
            resel_valid = 0; inv_ack = 0; inv_dirty = 0;
            if (ev_done) begin
                dway = int'(ev_done_way);
                fin = 1;
            end else begin
                seen |= inv_valid;
                if (resel_req) begin
                    resel_valid = 1;
                    resel_way = 2'(nres == 0 ? rw0 : rw1);
                    resel_addr = a + 16'(nres + 1);
                    nres++;
                end
                inv_ack = inv_valid;
                @(negedge clk);
            end
        end
        resel_valid = 0; inv_ack = 0;
        if (!fin) chk("R6 eviction never completed", 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 ev_ready", ev_ready, 1);
        chk("R1 inv_valid", inv_valid, 0);
        chk("R1 wb_valid", wb_valid, 0);
        chk("R1 resel_req", resel_req, 0);
        chk("R1 ev_done", ev_done, 0);
    endtask

    task automatic t_empty();
        logic [1:0] sn; int nr, dw;
        run_evict(3, 1, 16'h0310, 0, 0, 0, sn, nr, dw);
        chk("R3 no inv on clear bits", sn, 0);
        chk("R1 no resel after reset", nr, 0);
        chk("R3 done way", dw, 1);
    endtask

    task automatic t_single();
        logic [1:0] sn; int nr, dw;
        do_fill(0, 2, 0, 0, 0, 0);
        run_evict(2, 0, 16'h0200, 1, 0, 0, sn, nr, dw);
        chk("R2 R3 inv only cache0", sn, 2'b01);
        chk("R7 clean ack no writeback", wb_valid, 0);
        run_evict(2, 0, 16'h0200, 1, 0, 0, sn, nr, dw);
        chk("R12 entry cleared after eviction", sn, 0);
    endtask

    task automatic t_two_sharers_dirty();
        bit got = 0, done_seen = 0;
        do_fill(0, 5, 2, 0, 0, 0);
        do_fill(1, 5, 2, 0, 0, 0);
        @(negedge clk);
        ev_valid = 1; ev_set = 5; ev_way = 2; ev_addr = 16'h0552; ev_coh = 1;
        @(negedge clk);
        ev_valid = 0;
        for (int k = 0; k < 10 && !got; k++) begin
            if (inv_valid != 0) got = 1;
            else @(negedge clk);
        end
        chk("R3 both sharers targeted", inv_valid, 2'b11);
        chk("R11 coherent eviction no resel", resel_req, 0);
        inv_ack = 2'b10; inv_dirty = 2'b10; inv_data[63:32] = 32'hD1D1_0001;
        #1 chk("R6 cache1 ack accepted first", inv_ack_ready, 2'b10);
        @(negedge clk);
        chk("R6 cache0 still pending", inv_valid, 2'b01);
        chk("R6 not done before all acks", ev_done, 0);
        chk("R7 wb_valid", wb_valid, 1);
        chk("R7 wb_addr", wb_addr, 32'h0552);
        chk("R7 wb_data", wb_data, 32'hD1D1_0001);
        inv_ack = 2'b01; inv_dirty = 2'b00;
        #1 chk("R8 ack stalled while full", inv_ack_ready, 0);
        @(negedge clk);
        chk("R8 request held while full", inv_valid, 2'b01);
        chk("R6 still not done", ev_done, 0);
        chk("R7 wb held without ready", wb_valid, 1);
        wb_ready = 1;
        @(negedge clk);
        wb_ready = 0;
        chk("R7 wb drained", wb_valid, 0);
        #1 chk("R8 ack accepted after drain", inv_ack_ready, 2'b01);
        for (int k = 0; k < 6 && !done_seen; k++) begin
            @(negedge clk);
            inv_ack = 0;
            if (ev_done) done_seen = 1;
        end
        chk("R6 done after last ack", done_seen, 1);
        chk("R7 clean ack no second wb", wb_valid, 0);
    endtask

    task automatic t_note();
        logic [1:0] sn; int nr, dw;
        do_fill(1, 6, 3, 0, 0, 0);
        do_note(1, 6, 3);
        run_evict(6, 3, 16'h0630, 1, 0, 0, sn, nr, dw);
        chk("R4 notice cleared bit", sn, 0);
    endtask

    task automatic t_fill_victim();
        logic [1:0] sn; int nr, dw;
        do_fill(0, 7, 0, 0, 0, 0);
        do_fill(0, 7, 1, 1, 7, 0);
        run_evict(7, 0, 16'h0700, 1, 0, 0, sn, nr, dw);
        chk("R5 victim bit cleared at fill", sn, 0);
        run_evict(7, 1, 16'h0710, 1, 0, 0, sn, nr, dw);
        chk("R5 R2 filled entry present", sn, 2'b01);
    endtask

    task automatic t_resel_one();
        logic [1:0] sn; int nr, dw;
        do_fill(0, 9, 0, 0, 0, 0);
        run_evict(9, 0, 16'h0900, 0, 1, 1, sn, nr, dw);
        chk("R9 one reselection", nr, 1);
        chk("R9 new way evicted", dw, 1);
        chk("R9 no invalidation", sn, 0);
    endtask

    task automatic t_resel_max();
        logic [1:0] sn; int nr, dw;
        do_fill(0, 10, 0, 0, 0, 0);
        do_fill(0, 10, 1, 0, 0, 0);
        do_fill(0, 10, 2, 0, 0, 0);
        run_evict(10, 0, 16'h0A00, 0, 1, 2, sn, nr, dw);
        chk("R10 reselections capped", nr, 2);
        chk("R10 third victim evicted", dw, 2);
        chk("R10 forced invalidation", sn, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_single();
        t_two_sharers_dirty();
        t_note();
        t_fill_victim();
        t_resel_one();
        t_resel_max();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule